// File: doc/BRIEF.md
# Sliced Wave Issue Scheduler

This block picks, every clock cycle, which resident wave drives a narrow SIMD datapath. A wave holds 64 threads while the datapath handles 16 threads per cycle, so a single instruction of a wave goes out as four consecutive 16-thread slices. The scheduler keeps a slice counter for each resident wave and rotates between waves after every slice rather than after every instruction. When all waves are eligible, each slice position is issued for every wave before the next slice position starts.

A wave becomes blocked when the instruction it just finished issuing was a memory load. The datapath is free again in the next cycle. The blocked wave gets no further slots until a memory-return pulse carrying its wave number arrives. Until then its slots go to the other eligible waves. Each cycle the block reports whether anything issues, which wave, the slice index, and the first thread number of that slice.

Top module: `wave_slice_sched`

## Requirements
- R1: After reset no wave is blocked. Every slice counter is 0. The first grant goes to the lowest-numbered eligible wave, scanning upward from wave 0.
- R2: `issue_valid_o` is high in a cycle exactly when at least one wave has its ready bit set and is not blocked.
- R3: The granted wave is the first eligible wave found by scanning upward and circularly, starting at the wave after the last one granted.
- R4: `issue_slice_o` shows the granted wave's own slice counter. That counter advances by one each time the wave is granted and wraps from 3 to 0. Counters of waves that are not granted keep their value.
- R5: `issue_base_o` equals the slice index times 16. The slice covers threads base to base+15.
- R6: With all four waves eligible, successive grants follow wave 0, 1, 2, 3 at slice 0, then waves 0 to 3 at slice 1, and so on through slice 3.
- R7: A grant on slice 3 with `load_i` high blocks the granted wave from the next cycle onward. `wave_blocked_o` bit w shows wave w's blocked state.
- R8: `load_i` high during a grant on slice 0, 1 or 2 blocks no wave.
- R9: A cycle with `mem_ret_valid_i` high unblocks wave `mem_ret_wave_i` from the next cycle. A block being set on the same wave in the same cycle takes precedence.
- R10: In a cycle with no eligible wave, `issue_valid_o` is low. All slice counters and the last-granted wave hold their values.
- R11: `load_i` has no effect in a cycle where `issue_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wave_ready_i | input | 4 | Per-wave ready bit |
| load_i | input | 1 | The instruction being issued is a memory load |
| mem_ret_valid_i | input | 1 | Load data returned this cycle |
| mem_ret_wave_i | input | 2 | Wave that the returned data belongs to |
| issue_valid_o | output | 1 | A slice issues this cycle |
| issue_wave_o | output | 2 | Granted wave |
| issue_slice_o | output | 2 | Slice index of the grant |
| issue_base_o | output | 6 | First thread number of the slice |
| wave_blocked_o | output | 4 | Per-wave blocked state |

## Verification
The bench first runs the all-eligible pattern. A scheduler that rotated per instruction would issue four slices of wave 0 in a row, and one that shared a single slice counter would mis-number the slices. It then raises `load_i` on slices 0 to 2 and on idle cycles, where a design that blocked too eagerly would lose a wave. It drives every ready mask so the scan must wrap past wave 3, a point where an off-by-one pointer picks the wrong wave. It also covers an all-blocked idle stretch followed by returns: counters that crept forward while idle, or returns that cleared the wrong wave, show up as the wrong slice or a wave that never resumes.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
    function automatic int unsigned idx_bits(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] last_i,
    output logic          gnt_valid_o,
    output logic [IW-1:0] gnt_idx_o
);
    always_comb begin
        gnt_valid_o = 1'b0;
        gnt_idx_o   = last_i;
        for (int k = 1; k <= N; k++) begin
            int cand;
            cand = (int'(last_i) + k) % N;
            if (!gnt_valid_o && req_i[cand]) begin
                gnt_valid_o = 1'b1;
                gnt_idx_o   = IW'(cand);
            end
        end
    end
endmodule

// File: rtl/wave_block_track.sv
module wave_block_track #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_i,
    input  logic [IW-1:0] set_idx_i,
    input  logic          clr_i,
    input  logic [IW-1:0] clr_idx_i,
    output logic [N-1:0]  blocked_o
);
    logic [N-1:0] blk_d, blk_q;

    for (genvar w = 0; w < N; w++) begin : g_wave
        always_comb begin
            blk_d[w] = blk_q[w];
            if (clr_i && clr_idx_i == IW'(w)) blk_d[w] = 1'b0;
            if (set_i && set_idx_i == IW'(w)) blk_d[w] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) blk_q <= '0;
        else        blk_q <= blk_d;
    end

    assign blocked_o = blk_q;
endmodule

// File: rtl/wave_slice_sched.sv
module wave_slice_sched #(
    parameter int NUM_WAVES    = 4,
    parameter int WAVE_THREADS = 64,
    parameter int SIMD_LANES   = 16,
    localparam int SLICES = WAVE_THREADS / SIMD_LANES,
    localparam int IW     = wsched_pkg::idx_bits(NUM_WAVES),
    localparam int SW     = wsched_pkg::idx_bits(SLICES),
    localparam int TW     = wsched_pkg::idx_bits(WAVE_THREADS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WAVES-1:0] wave_ready_i,
    input  logic                 load_i,
    input  logic                 mem_ret_valid_i,
    input  logic [IW-1:0]        mem_ret_wave_i,
    output logic                 issue_valid_o,
    output logic [IW-1:0]        issue_wave_o,
    output logic [SW-1:0]        issue_slice_o,
    output logic [TW-1:0]        issue_base_o,
    output logic [NUM_WAVES-1:0] wave_blocked_o
);
    typedef struct packed {
        logic [IW-1:0]                 last;
        logic [NUM_WAVES-1:0][SW-1:0] slice;
    } sched_t;

    sched_t st_d, st_q;
    logic [NUM_WAVES-1:0] eligible;
    logic                 gnt_valid;
    logic [IW-1:0]        gnt_idx;
    logic                 last_slice;
    logic                 block_set;

    assign eligible = wave_ready_i & ~wave_blocked_o;

    rr_pick #(.N(NUM_WAVES), .IW(IW)) u_pick (
        .req_i       (eligible),
        .last_i      (st_q.last),
        .gnt_valid_o (gnt_valid),
        .gnt_idx_o   (gnt_idx)
    );

    assign last_slice = (st_q.slice[gnt_idx] == SW'(SLICES - 1));
    assign block_set  = gnt_valid && load_i && last_slice;

    wave_block_track #(.N(NUM_WAVES), .IW(IW)) u_block (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (block_set),
        .set_idx_i (gnt_idx),
        .clr_i     (mem_ret_valid_i),
        .clr_idx_i (mem_ret_wave_i),
        .blocked_o (wave_blocked_o)
    );

    always_comb begin
        st_d = st_q;
        if (gnt_valid) begin
            st_d.last = gnt_idx;
            if (last_slice) st_d.slice[gnt_idx] = '0;
            else            st_d.slice[gnt_idx] = st_q.slice[gnt_idx] + SW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.last  <= IW'(NUM_WAVES - 1);
            st_q.slice <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_valid_o = gnt_valid;
    assign issue_wave_o  = gnt_idx;
    assign issue_slice_o = st_q.slice[gnt_idx];
    assign issue_base_o  = TW'(st_q.slice[gnt_idx]) * TW'(SIMD_LANES);
endmodule

// File: rtl/wsched_checker.sv
module wsched_checker #(
    parameter int NUM_WAVES = 4,
    parameter int IW        = 2,
    parameter int SW        = 2,
    parameter int TW        = 6,
    parameter int SLICES    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_WAVES-1:0] wave_ready_i,
    input logic                 load_i,
    input logic                 mem_ret_valid_i,
    input logic [IW-1:0]        mem_ret_wave_i,
    input logic                 issue_valid_o,
    input logic [IW-1:0]        issue_wave_o,
    input logic [SW-1:0]        issue_slice_o,
    input logic [TW-1:0]        issue_base_o,
    input logic [NUM_WAVES-1:0] wave_blocked_o
);
    p_valid_iff_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o == (|(wave_ready_i & ~wave_blocked_o)));

    p_grant_is_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |-> (wave_ready_i[issue_wave_o] && !wave_blocked_o[issue_wave_o]));

    p_load_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o && load_i && issue_slice_o == SW'(SLICES - 1))
        |=> wave_blocked_o[$past(issue_wave_o)]);

    p_block_needs_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(wave_blocked_o & ~$past(wave_blocked_o)))
        |-> $past(issue_valid_o && load_i && issue_slice_o == SW'(SLICES - 1)));

    p_return_unblocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ret_valid_i && !(issue_valid_o && issue_wave_o == mem_ret_wave_i))
        |=> !wave_blocked_o[$past(mem_ret_wave_i)]);

    p_base_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |-> (issue_base_o % TW'(16) == '0));
endmodule

bind wave_slice_sched wsched_checker #(
    .NUM_WAVES(NUM_WAVES), .IW(IW), .SW(SW), .TW(TW), .SLICES(SLICES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wave_ready_i(wave_ready_i), .load_i(load_i),
    .mem_ret_valid_i(mem_ret_valid_i), .mem_ret_wave_i(mem_ret_wave_i),
    .issue_valid_o(issue_valid_o), .issue_wave_o(issue_wave_o),
    .issue_slice_o(issue_slice_o), .issue_base_o(issue_base_o),
    .wave_blocked_o(wave_blocked_o)
);

// File: tb/sim_wave_slice_sched.sv
module sim_wave_slice_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ready = '0;
    logic       load = 1'b0;
    logic       ret_v = 1'b0;
    logic [1:0] ret_id = '0;
    logic       v;
    logic [1:0] wv;
    logic [1:0] sl;
    logic [5:0] base;
    logic [3:0] blk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int   slice_m [4];
    int   last_m;
    logic [3:0] blk_m;

    always #10 clk = ~clk;

    wave_slice_sched u0 (
        .clk(clk), .rst_n(rst_n), .wave_ready_i(ready), .load_i(load),
        .mem_ret_valid_i(ret_v), .mem_ret_wave_i(ret_id),
        .issue_valid_o(v), .issue_wave_o(wv), .issue_slice_o(sl),
        .issue_base_o(base), .wave_blocked_o(blk)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [3:0] r, input logic ld, input logic rv, input logic [1:0] rid);
        logic [3:0] elig;
        bit   ev;
        int   ew;
        @(negedge clk);
        ready = r; load = ld; ret_v = rv; ret_id = rid;
        #5;
        elig = r & ~blk_m;
        ev = 0; ew = last_m;
        for (int k = 1; k <= 4; k++) begin
            int c;
            c = (last_m + k) % 4;
            if (!ev && elig[c]) begin ev = 1; ew = c; end
        end
        chk(v == ev, "R2 valid", v, ev);
        chk(blk == blk_m, "R7 blocked", blk, blk_m);
        if (ev) begin
            chk(wv == ew, "R3 wave", wv, ew);
            chk(sl == slice_m[ew], "R4 slice", sl, slice_m[ew]);
            chk(base == slice_m[ew] * 16, "R5 base", base, slice_m[ew] * 16);
        end
        if (rv) blk_m[rid] = 1'b0;
        if (ev) begin
            if (ld && slice_m[ew] == 3) blk_m[ew] = 1'b1;
            slice_m[ew] = (slice_m[ew] + 1) % 4;
            last_m = ew;
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < 4; i++) slice_m[i] = 0;
        last_m = 3;
        blk_m = '0;
        repeat (3) @(negedge clk);
        #5;
        chk(v == 1'b0, "R1 idle in reset", v, 0);
        chk(blk == 4'b0, "R1 blocked in reset", blk, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6 all eligible: arithmetic pattern
        for (int i = 0; i < 16; i++) begin
            step(4'hF, 1'b0, 1'b0, 2'd0);
            chk(wv == i % 4, "R6 wave order", wv, i % 4);
            chk(sl == (i / 4) % 4, "R6 slice order", sl, (i / 4) % 4);
            if (i == 0) chk(wv == 0 && sl == 0, "R1 first grant", wv, 0);
        end

        // R8 load on slices 0..2 ignored
        for (int i = 0; i < 12; i++) begin
            step(4'hF, 1'b1, 1'b0, 2'd0);
            chk(blk == 4'b0, "R8 no block early slice", blk, 0);
        end
        // R11 load while idle ignored
        step(4'h0, 1'b1, 1'b0, 2'd0);
        chk(v == 1'b0, "R11 idle", v, 0);
        step(4'h0, 1'b1, 1'b0, 2'd0);
        chk(blk == 4'b0, "R11 no block when idle", blk, 0);

        // R7 slice-3 loads block every wave
        for (int i = 0; i < 4; i++) step(4'hF, 1'b1, 1'b0, 2'd0);
        step(4'hF, 1'b0, 1'b0, 2'd0);
        chk(blk == 4'hF, "R7 all blocked", blk, 15);
        chk(v == 1'b0, "R10 no grant when all blocked", v, 0);
        step(4'hF, 1'b1, 1'b1, 2'd2);
        step(4'hF, 1'b0, 1'b0, 2'd0);
        chk(v && wv == 2 && sl == 0, "R9 returned wave resumes", {v, wv, sl}, {1'b1, 2'd2, 2'd0});
        chk(blk == 4'b1011, "R9 only wave 2 cleared", blk, 4'b1011);
        step(4'hF, 1'b0, 1'b1, 2'd0);
        step(4'hF, 1'b0, 1'b1, 2'd1);
        step(4'hF, 1'b0, 1'b1, 2'd3);
        step(4'hF, 1'b0, 1'b0, 2'd0);
        chk(blk == 4'b0, "R9 all returned", blk, 0);

        // R10 sweep of every ready mask, with idle stretches
        for (int m = 0; m < 16; m++) begin
            for (int j = 0; j < 7; j++) step(4'(m), 1'b0, 1'b0, 2'd0);
            step(4'h0, 1'b0, 1'b0, 2'd0);
        end

        // mixed pseudo-random traffic
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[3:0] | lf[12:9], lf[4] | lf[5], lf[6], lf[8:7]);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule